// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write an external asynchronous static RAM of 64K words by 16 bits. The host raises a request with an address, write data, a two-bit byte mask and a read/write flag, then holds it until the controller answers with a one-cycle ready pulse. On a read, the returned word is in a register when ready is high.

On the memory side the controller drives active-low chip select, output enable, write strobe and one strobe per byte lane. The 16-bit data path is split into an output word, an input word and an explicit drive enable, so that the pads can sit outside this block. A write happens only while chip select, the write strobe and at least one lane strobe are all low. Output enable stays high for the whole write. The bus drivers are switched off at least one cycle before output enable falls for a read. Every phase length is a parameter given in picoseconds and is rounded up to whole clock periods.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, all five memory strobes are high, the drive enable is low and ready is low.
- R2: A write changes only the lanes whose mask bit is set. Mask bit 0 selects bits 7:0 through the lower lane strobe and mask bit 1 selects bits 15:8 through the upper lane strobe. The other lane of the stored word keeps its value.
- R3: A read returns the stored value in the lanes whose mask bit is set, and zero in the lanes whose mask bit is clear.
- R4: Each write holds the write strobe low for exactly ceil(WE_PULSE_PS / CLK_PERIOD_PS) consecutive cycles (at least one). Chip select is low and output enable is high in each of those cycles.
- R5: The drive enable is high only while output enable is high.
- R6: Output enable falls only after a cycle in which the drive enable was low. The memory and the controller never drive the bus in the same cycle.
- R7: The memory address does not change while chip select stays low.
- R8: Ready is high for exactly one cycle per transaction.
- R9: With a byte mask of zero, no lane strobe goes low. The transaction still completes with ready, a read returns zero, and a write leaves the memory unchanged.
- R10: Counted from the clock edge that accepts the request, ready rises after ASU+WE+1 edges for a write and after TA+RD edges for a read. Each term is its picosecond parameter rounded up to whole periods, with a minimum of 1.
- R11: Chip select is high in the ready cycle and whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access (bit 1 upper, bit 0 lower) |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Registered read data, valid with ready |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data seen on the bus |

## Verification
The assertions watch the bus discipline on every cycle. They check that drivers are on only while output enable is high and that output enable never falls straight after a driving cycle. They also check that the write strobe only appears with chip select low and output enable high, that the address holds while selected, and that ready is a single-cycle pulse. Only the bench scenarios can show the data results against a memory model: which lanes a masked write really changes, the zeroing of unselected read lanes, the exact write-strobe width, the per-transaction latency, and the empty-mask case.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SRAM byte-lane controller.
// Assumes every phase is at least one clock long.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WSTROBE,
        ST_WHOLD,
        ST_RTURN,
        ST_RACC,
        ST_DONE
    } seq_state_e;

    // Rounds a time in picoseconds up to whole clock periods, minimum one.
    function automatic int unsigned ps_to_cycles(input int unsigned ps,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ps + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Loadable down counter that measures the length of one phase.
// Load the phase length minus one; 'last' is high in the final cycle.
// Assumes load is pulsed only on phase entry.
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Counts down to zero and holds there until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks one transaction through setup, strobe, hold
// (write) or turnaround, access (read), then a single ready cycle.
// It decodes all memory strobes and the bus drive enable from the state.
// Assumes the request fields stay stable while req is high in idle.
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ASU_CYC = 1,
    parameter int WE_CYC  = 1,
    parameter int TA_CYC  = 1,
    parameter int RD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [LANES-1:0] mask,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);
    localparam int MAXC = int'(max2(max2(ASU_CYC, WE_CYC), max2(TA_CYC, RD_CYC)));
    localparam int CW   = $clog2(MAXC) + 1;

    localparam logic [CW-1:0] ASU_LD = CW'(ASU_CYC - 1);
    localparam logic [CW-1:0] WE_LD  = CW'(WE_CYC - 1);
    localparam logic [CW-1:0] TA_LD  = CW'(TA_CYC - 1);
    localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);

    seq_state_e    state_q, state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // Holds the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Chooses the next phase and loads the timer on each phase entry.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                if (req_write) begin
                    state_d = ST_WSETUP;
                    tmr_val = ASU_LD;
                end else begin
                    state_d = ST_RTURN;
                    tmr_val = TA_LD;
                end
            end
            ST_WSETUP: if (tmr_last) begin
                state_d  = ST_WSTROBE;
                tmr_load = 1'b1;
                tmr_val  = WE_LD;
            end
            ST_WSTROBE: if (tmr_last) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_DONE;
            ST_RTURN: if (tmr_last) begin
                state_d  = ST_RACC;
                tmr_load = 1'b1;
                tmr_val  = RD_LD;
            end
            ST_RACC: if (tmr_last) begin
                capture = 1'b1;
                state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Decodes the memory strobes and the drive enable from the phase.
    always_comb begin
        ce_n   = (state_q == ST_IDLE) || (state_q == ST_DONE);
        oe_n   = (state_q != ST_RACC);
        we_n   = (state_q != ST_WSTROBE);
        lane_n = ((state_q == ST_WSTROBE) || (state_q == ST_RACC)) ? ~mask : '1;
        dq_oe  = (state_q == ST_WSTROBE) || (state_q == ST_WHOLD);
        ready  = (state_q == ST_DONE);
    end

    // Checks on the sequencer outputs.
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n));
    p_drive_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(dq_oe));
    p_ce_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ce_n);
    p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (lane_n == '1));

endmodule

// File: rtl/sram_lane_datapath.sv
`timescale 1ns/1ps
// Request register and read-capture register for the controller.
// It latches the host fields when a request is accepted and captures the
// bus per byte lane at the end of a read. Lanes outside the mask read as zero.
// Assumes the data width is a whole number of bytes.
module sram_lane_datapath #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             capture,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    input  logic [DW-1:0]    dq_in,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic [LANES-1:0] mask_q,
    output logic [DW-1:0]    rdata_q
);
    // Latches the host request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Captures one byte lane, or zero when the lane is not selected.
        always_ff @(posedge clk) begin
            if (!rst_n)       rdata_q[l*8 +: 8] <= '0;
            else if (capture) rdata_q[l*8 +: 8] <= mask_q[l] ? dq_in[l*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM byte-lane controller.
// It turns picosecond timing limits into cycle counts and connects the
// sequencer to the request and capture registers.
// Assumes the host holds req until the ready pulse.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW             = 16,
    parameter int DW             = 16,
    parameter int CLK_PERIOD_PS  = 10000,
    parameter int ADDR_SETUP_PS  = 0,
    parameter int WE_PULSE_PS    = 8000,
    parameter int BUS_RELEASE_PS = 4000,
    parameter int READ_ACCESS_PS = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    output logic          rsp_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int LANES   = DW / 8;
    localparam int ASU_CYC = int'(ps_to_cycles(ADDR_SETUP_PS,  CLK_PERIOD_PS));
    localparam int WE_CYC  = int'(ps_to_cycles(WE_PULSE_PS,    CLK_PERIOD_PS));
    localparam int TA_CYC  = int'(ps_to_cycles(BUS_RELEASE_PS, CLK_PERIOD_PS));
    localparam int RD_CYC  = int'(ps_to_cycles(READ_ACCESS_PS, CLK_PERIOD_PS));

    logic             accept, capture;
    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] lane_n;

    sram_seq_fsm #(
        .LANES   (LANES),
        .ASU_CYC (ASU_CYC),
        .WE_CYC  (WE_CYC),
        .TA_CYC  (TA_CYC),
        .RD_CYC  (RD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .mask      (mask_q),
        .accept    (accept),
        .capture   (capture),
        .ready     (rsp_ready),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .lane_n    (lane_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_lane_datapath #(
        .AW    (AW),
        .DW    (DW),
        .LANES (LANES)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask[LANES-1:0]),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .mask_q    (mask_q),
        .rdata_q   (rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[LANES-1];

    // The address must hold for the whole selected interval.
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected results, and a monitor pops
// and compares them at each ready pulse. A small SRAM model answers the bus.
module sram_lane_ctrl_tb;
    localparam int PER_PS = 5000;
    localparam int WE_C   = (8000  + PER_PS - 1) / PER_PS;
    localparam int ASU_C  = 1;
    localparam int TA_C   = (4000  + PER_PS - 1) / PER_PS;
    localparam int RD_C   = (10000 + PER_PS - 1) / PER_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_ready;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.CLK_PERIOD_PS(PER_PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model, indexed by the low address byte.
    logic [15:0] sram  [256];
    logic [15:0] shadow[256];
    logic        mdl_drive;
    initial for (int i = 0; i < 256; i++) begin sram[i] = '0; shadow[i] = '0; end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) sram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) sram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    always_comb begin
        mdl_drive = !mem_ce_n && !mem_oe_n && mem_we_n && !(mem_ub_n && mem_lb_n);
        mem_dq_in[7:0]  = (mdl_drive && !mem_lb_n) ? sram[mem_addr[7:0]][7:0]  : 8'hA5;
        mem_dq_in[15:8] = (mdl_drive && !mem_ub_n) ? sram[mem_addr[7:0]][15:8] : 8'hA5;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    typedef struct {
        bit          is_read;
        logic [15:0] addr;
        logic [15:0] data;
        int          lat;
        int          strobe_cyc;
    } item_t;
    item_t sb[$];

    // Counts posedges while a request is pending.
    int busy_cyc = 0;
    always @(posedge clk) busy_cyc <= req ? busy_cyc + 1 : 0;

    // Monitor: bus discipline every cycle, scoreboard at each ready.
    int  we_run = 0, lane_cyc = 0, overlap = 0, drive_low_oe = 0;
    bit  prev_ready = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (mdl_drive && mem_dq_oe) overlap++;
        if (mem_dq_oe && !mem_oe_n) drive_low_oe++;
        if (!mem_ub_n || !mem_lb_n) lane_cyc++;
        if (!mem_we_n) begin
            we_run++;
            chk(!mem_ce_n && mem_oe_n, "R4 ce low oe high during write", {mem_ce_n, mem_oe_n}, 2'b01);
        end else if (we_run != 0) begin
            chk(we_run == WE_C, "R4 write strobe width", we_run, WE_C);
            we_run = 0;
        end
        if (rsp_ready) begin
            chk(!prev_ready, "R8 single ready pulse", prev_ready, 0);
            chk(mem_ce_n, "R11 ce high at ready", mem_ce_n, 1);
            if (sb.size() == 0) chk(0, "R8 unexpected ready", 1, 0);
            else begin
                item_t it;
                it = sb.pop_front();
                chk(busy_cyc == it.lat, it.is_read ? "R10 read latency" : "R10 write latency", busy_cyc, it.lat);
                chk(mem_addr == it.addr, "R7 address held", mem_addr, it.addr);
                chk(lane_cyc == it.strobe_cyc, "R9 R2 lane strobe cycles", lane_cyc, it.strobe_cyc);
                if (it.is_read) chk(rsp_rdata == it.data, "R3 read data", rsp_rdata, it.data);
            end
            lane_cyc = 0;
        end
        prev_ready = rsp_ready;
    end

    // Drives one request and waits for its completion.
    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        item_t it;
        logic [15:0] cur;
        cur = shadow[a[7:0]];
        it.is_read = !wr;
        it.addr    = a;
        it.lat     = (wr ? (ASU_C + WE_C + 1) : (TA_C + RD_C)) + 1;
        it.strobe_cyc = (m == 2'b00) ? 0 : (wr ? WE_C : RD_C);
        it.data    = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
        if (wr) begin
            if (m[0]) cur[7:0]  = d[7:0];
            if (m[1]) cur[15:8] = d[15:8];
            shadow[a[7:0]] = cur;
        end
        sb.push_back(it);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        do @(negedge clk); while (!rsp_ready);
        req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1 strobes high in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
        chk(!mem_dq_oe && !rsp_ready, "R1 drive and ready low in reset", {mem_dq_oe, rsp_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ready, "R1 idle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ready}, 5'b11100);
        issue(1, 16'h0012, 16'hBEEF, 2'b11);   // R2 full word
        issue(0, 16'h0012, 16'h0000, 2'b11);   // R3
        issue(1, 16'h0012, 16'h1234, 2'b01);   // R2 lower lane only
        issue(0, 16'h0012, 16'h0000, 2'b11);
        issue(1, 16'h0012, 16'h5600, 2'b10);   // R2 upper lane only
        issue(0, 16'h0012, 16'h0000, 2'b11);
        issue(0, 16'h0012, 16'h0000, 2'b01);   // R3 upper lane reads zero
        issue(0, 16'h0012, 16'h0000, 2'b10);   // R3 lower lane reads zero
        issue(1, 16'h0340, 16'hCAFE, 2'b00);   // R9 empty write
        issue(0, 16'h0340, 16'h0000, 2'b11);   // R9 memory unchanged
        issue(0, 16'h0012, 16'h0000, 2'b00);   // R9 empty read
        issue(1, 16'hFF77, 16'h0F0F, 2'b11);
        issue(0, 16'hFF77, 16'h0000, 2'b11);
        issue(0, 16'h0012, 16'h0000, 2'b11);   // R2 other address untouched
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R8 every request answered", sb.size(), 0);
        chk(overlap == 0, "R6 no bus overlap", overlap, 0);
        chk(drive_low_oe == 0, "R5 drive only with oe high", drive_low_oe, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule